// File: doc/BRIEF.md
# Multi-Rate TDM Serial Stream Framer

This block terminates one serial time-division-multiplexed input lane and sources one serial output lane. Both lanes share a single bit clock and frame pulse coming from off-chip. These signals are oversampled by the fast system clock `clk`. The block finds the active clock edge and the frame boundary, and it counts tick, bit and channel positions within the 125 µs frame. It gathers received bits into channel bytes, and it shifts channel bytes supplied by the core out onto the output lane.

The input rate and the output rate each take one of four values and are set independently. The shared bit clock runs at twice the faster of the two rates, or at the rate itself when the faster rate is 16.384 Mbps. The slower lane spreads each of its bits over more clock ticks. The active clock edge, the level of the frame pulse and the position of the frame pulse are all programmable. In bidirectional mode the received data comes from the output pad instead of the dedicated input. All control inputs are static: they are changed only while `rst_n` is low.

Top module: `tdm_stream_framer`

## Requirements
- R1: A rate code of 00, 01, 10 or 11 selects 2.048, 4.096, 8.192 or 16.384 Mbps, which is 32, 64, 128 or 256 byte channels per frame. Channels are numbered from 0 at the frame boundary, and `rx_chan`/`tx_chan` carry that number.
- R2: Let F be the larger of the input and output rate codes. The frame holds 512<<F clock ticks when F is 0 or 1, and 2048 ticks when F is 2 or 3. A lane at rate code r uses (ticks per frame)/(256<<r) ticks per bit. This gives two ticks per bit at the fastest lower rate and one tick per bit at 16.384 Mbps.
- R3: The input and output lanes follow their own rate codes at the same time, so a lane can be faster or slower than the other.
- R4: With `ck_pol`=0 (the default format) the falling edge of `tdm_ck` is the active tick. With `ck_pol`=1 the rising edge is the active tick.
- R5: `tdm_fp` is asserted low when `fp_pol`=0 (the default) and asserted high when `fp_pol`=1. It is sampled only on active ticks.
- R6: With `fp_pos`=0, the tick after a tick that sampled the pulse asserted is tick 0 of the frame. With `fp_pos`=1, the tick that samples the pulse is itself tick 0. The counter also wraps to 0 after the last tick of a frame.
- R7: Each input bit is sampled on the last tick of its bit period, most significant bit first. When the eighth bit of a channel is taken, `rx_byte` and `rx_chan` update and `rx_valid` is high for exactly one `clk` cycle.
- R8: The output bit changes on the first tick of each bit period, most significant bit first. On the first tick of a channel, the byte on `tx_byte` is loaded for the channel named on `tx_chan` during that tick.
- R9: With `bidir_en`=1, received data is taken from `pad_in` and `ser_in` has no effect.
- R10: While `out_en` is low, `ser_oe` is low.
- R11: Reset clears all counters and holds `ser_oe` and `rx_valid` low. Until the first frame pulse is aligned, no byte is received, `ser_oe` stays low and `ser_out` stays 0.
- R12: A tick takes effect at the outputs on the second rising edge of `clk` after the active `tdm_ck` transition, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the TDM timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdm_ck | input | 1 | Shared TDM bit clock |
| tdm_fp | input | 1 | Shared frame pulse |
| ser_in | input | 1 | Dedicated serial data input |
| pad_in | input | 1 | Data read back from the output pad |
| bidir_en | input | 1 | Take received data from the pad |
| out_en | input | 1 | Output drive enable |
| in_rate | input | 2 | Input lane rate code |
| out_rate | input | 2 | Output lane rate code |
| ck_pol | input | 1 | Active clock edge select |
| fp_pol | input | 1 | Frame pulse level select |
| fp_pos | input | 1 | Frame pulse position select |
| tx_byte | input | 8 | Byte for the channel named on tx_chan |
| tx_chan | output | 8 | Output channel whose byte is requested |
| ser_out | output | 1 | Serial output data |
| ser_oe | output | 1 | Output driver enable |
| rx_byte | output | 8 | Last completed input byte |
| rx_chan | output | 8 | Channel of rx_byte |
| rx_valid | output | 1 | One-cycle strobe for a new rx_byte |

## Verification
The bench keeps its own tick-level model of frame position, bit timing and byte assembly, and compares it with the ports on every TDM tick. A tick counter that is off by one shows up at the next channel boundary, where `rx_chan` or the serial output bit disagrees. A wrong ticks-per-bit shift shows up within the first received byte after lock. A misread of the clock edge or of the frame pulse convention either prevents lock or moves every byte, so `ser_oe` or the first `rx_valid` is wrong within one frame. Sampling one `clk` cycle early or late is caught by the latency check, which runs between the two sampling edges of every tick.

// File: rtl/tdm_framer_pkg.sv
package tdm_framer_pkg;

  localparam int POS_W     = 11;
  localparam int BYTE_W    = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);
  localparam int CH_W      = POS_W - BIT_IDX_W;

  typedef logic [1:0] rate_t;

  // log2 of ticks per bit for a lane at rate r when the clock is set by code f
  function automatic logic [1:0] ticks_log2(input rate_t f, input rate_t r);
    if (f == 2'd3) return 2'(2'd3 - r);
    else           return 2'(f + 2'd1 - r);
  endfunction

  // index of the last tick of a frame for clock code f
  function automatic logic [POS_W-1:0] frame_last(input rate_t f);
    case (f)
      2'd0:    return POS_W'(511);
      2'd1:    return POS_W'(1023);
      default: return POS_W'(2047);
    endcase
  endfunction

endpackage

// File: rtl/tdm_edge_sampler.sv
module tdm_edge_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic ck_pad,
  input  logic fp_pad,
  input  logic dat_pad,
  input  logic ck_pol,
  input  logic fp_pol,
  output logic tick,
  output logic fp_act,
  output logic dat_smp
);

  logic ck_q, ck_qq, fp_q, dat_q;
  logic lvl_now, lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q  <= 1'b0;
      ck_qq <= 1'b0;
      fp_q  <= 1'b0;
      dat_q <= 1'b0;
    end else begin
      ck_q  <= ck_pad;
      ck_qq <= ck_q;
      fp_q  <= fp_pad;
      dat_q <= dat_pad;
    end
  end

  always_comb begin
    lvl_now  = ck_q  ~^ ck_pol;
    lvl_prev = ck_qq ~^ ck_pol;
    tick     = lvl_now & ~lvl_prev;
    fp_act   = fp_q ~^ fp_pol;
    dat_smp  = dat_q;
  end

endmodule

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr
  import tdm_framer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fp_act,
  input  logic             fp_pos,
  input  rate_t            ck_code,
  output logic [POS_W-1:0] idx,
  output logic             act,
  output logic             locked
);

  logic [POS_W-1:0] pos_q, pos_d, last;
  logic             fpl_q, fpl_d, lock_q, lock_d, align;

  always_comb begin
    last   = frame_last(ck_code);
    align  = fp_pos ? fp_act : fpl_q;
    idx    = align ? '0 : ((pos_q == last) ? '0 : pos_q + 1'b1);
    pos_d  = pos_q;
    fpl_d  = fpl_q;
    lock_d = lock_q;
    if (tick) begin
      pos_d  = idx;
      fpl_d  = fp_act;
      lock_d = lock_q | align;
    end
    act    = tick & (lock_q | align);
    locked = lock_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      fpl_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      fpl_q  <= fpl_d;
      lock_q <= lock_d;
    end
  end

  assert_pos_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= frame_last(ck_code));

  assert_lock_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> (pos_q == '0));

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
  import tdm_framer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic [POS_W-1:0]  idx,
  input  logic [1:0]        shift,
  input  logic              din,
  output logic [BYTE_W-1:0] rx_byte,
  output logic [CH_W-1:0]   rx_chan,
  output logic              rx_valid
);

  logic [POS_W-1:0]  bit_no, mask;
  logic              take, done;
  logic [BYTE_W-1:0] sh_q, sh_d, byte_q, byte_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic              vld_q;

  always_comb begin
    bit_no = idx >> shift;
    mask   = ~({POS_W{1'b1}} << shift);
    take   = act & ((idx & mask) == mask);
    done   = take & (bit_no[BIT_IDX_W-1:0] == BIT_IDX_W'(BYTE_W-1));
    sh_d   = take ? {sh_q[BYTE_W-2:0], din} : sh_q;
    byte_d = done ? {sh_q[BYTE_W-2:0], din} : byte_q;
    chan_d = done ? bit_no[POS_W-1:BIT_IDX_W] : chan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      byte_q <= '0;
      chan_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      byte_q <= byte_d;
      chan_q <= chan_d;
      vld_q  <= done;
    end
  end

  assign rx_byte  = byte_q;
  assign rx_chan  = chan_q;
  assign rx_valid = vld_q;

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
  import tdm_framer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic [POS_W-1:0]  idx,
  input  logic [1:0]        shift,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic [CH_W-1:0]   tx_chan,
  output logic              ser_out
);

  logic [POS_W-1:0]  bit_no, mask;
  logic              start, load;
  logic [BYTE_W-1:0] sh_q, sh_d;

  always_comb begin
    bit_no  = idx >> shift;
    mask    = ~({POS_W{1'b1}} << shift);
    start   = act & ((idx & mask) == '0);
    load    = start & (bit_no[BIT_IDX_W-1:0] == '0);
    tx_chan = bit_no[POS_W-1:BIT_IDX_W];
    if (load)       sh_d = tx_byte;
    else if (start) sh_d = {sh_q[BYTE_W-2:0], 1'b0};
    else            sh_d = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign ser_out = sh_q[BYTE_W-1];

  assert_out_moves_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> $stable(ser_out));

endmodule

// File: rtl/tdm_stream_framer.sv
module tdm_stream_framer
  import tdm_framer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tdm_ck,
  input  logic       tdm_fp,
  input  logic       ser_in,
  input  logic       pad_in,
  input  logic       bidir_en,
  input  logic       out_en,
  input  logic [1:0] in_rate,
  input  logic [1:0] out_rate,
  input  logic       ck_pol,
  input  logic       fp_pol,
  input  logic       fp_pos,
  input  logic [7:0] tx_byte,
  output logic [7:0] tx_chan,
  output logic       ser_out,
  output logic       ser_oe,
  output logic [7:0] rx_byte,
  output logic [7:0] rx_chan,
  output logic       rx_valid
);

  rate_t            ck_code;
  logic [1:0]       sh_in, sh_out;
  logic             din_sel, tick, fp_act, dat_smp, act, locked;
  logic [POS_W-1:0] idx;

  always_comb begin
    ck_code = (in_rate > out_rate) ? in_rate : out_rate;
    sh_in   = ticks_log2(ck_code, in_rate);
    sh_out  = ticks_log2(ck_code, out_rate);
    din_sel = bidir_en ? pad_in : ser_in;
  end

  tdm_edge_sampler smp_i (
    .clk(clk), .rst_n(rst_n), .ck_pad(tdm_ck), .fp_pad(tdm_fp), .dat_pad(din_sel),
    .ck_pol(ck_pol), .fp_pol(fp_pol), .tick(tick), .fp_act(fp_act), .dat_smp(dat_smp)
  );

  tdm_frame_ctr ctr_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fp_act(fp_act), .fp_pos(fp_pos),
    .ck_code(ck_code), .idx(idx), .act(act), .locked(locked)
  );

  tdm_rx_deser rx_i (
    .clk(clk), .rst_n(rst_n), .act(act), .idx(idx), .shift(sh_in), .din(dat_smp),
    .rx_byte(rx_byte), .rx_chan(rx_chan), .rx_valid(rx_valid)
  );

  tdm_tx_ser tx_i (
    .clk(clk), .rst_n(rst_n), .act(act), .idx(idx), .shift(sh_out),
    .tx_byte(tx_byte), .tx_chan(tx_chan), .ser_out(ser_out)
  );

  assign ser_oe = out_en & locked;

  assert_rx_after_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> locked);

  assert_quiet_before_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !ser_out);

endmodule

// File: tb/tdm_stream_framer_tb_top.sv
module tdm_stream_framer_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, tdm_ck, tdm_fp, ser_in, pad_in, bidir_en, out_en;
  logic       ck_pol, fp_pol, fp_pos, ser_out, ser_oe, rx_valid;
  logic [1:0] in_rate, out_rate;
  logic [7:0] tx_byte, tx_chan, rx_byte, rx_chan;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  function automatic logic [7:0] pat(input logic [7:0] ch);
    return (ch * 8'd29) ^ 8'hA5;
  endfunction

  assign tx_byte = pat(tx_chan);

  tdm_stream_framer dut_i (
    .clk(clk), .rst_n(rst_n), .tdm_ck(tdm_ck), .tdm_fp(tdm_fp), .ser_in(ser_in),
    .pad_in(pad_in), .bidir_en(bidir_en), .out_en(out_en), .in_rate(in_rate),
    .out_rate(out_rate), .ck_pol(ck_pol), .fp_pol(fp_pol), .fp_pos(fp_pos),
    .tx_byte(tx_byte), .tx_chan(tx_chan), .ser_out(ser_out), .ser_oe(ser_oe),
    .rx_byte(rx_byte), .rx_chan(rx_chan), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string lbl, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", lbl, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic run_phase(input int ir, input int orr, input bit ckp, input bit fpp,
                           input bit fpos, input bit bd, input int nticks,
                           input int oe_a, input int oe_b, input string lbl);
    int f, tpf, tpi, tpo, gen_t, pos_m, idx, b, acc, exp_out, prev_out, exp_c, exp_b;
    bit fpl_m, lock_m, align, fp_hit, sdin, pdin, deff, oe, exp_v, prev_lock;
    @(negedge clk);
    rst_n = 1'b0;
    in_rate = 2'(ir); out_rate = 2'(orr);
    ck_pol = ckp; fp_pol = fpp; fp_pos = fpos; bidir_en = bd; out_en = 1'b1;
    tdm_ck = ~ckp; tdm_fp = ~fpp; ser_in = 1'b0; pad_in = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    chk(ser_oe == 1'b0, "R11", "ser_oe in reset", int'(ser_oe), 0);
    chk(rx_valid == 1'b0, "R11", "rx_valid in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    f   = (ir > orr) ? ir : orr;
    tpf = (f >= 2) ? 2048 : (512 << f);
    tpi = tpf / (256 << ir);
    tpo = tpf / (256 << orr);
    gen_t = tpf - 2;
    pos_m = 0; fpl_m = 0; lock_m = 0; acc = 0; exp_out = 0;
    for (int k = 0; k < nticks; k++) begin
      fp_hit = ((gen_t % tpf) == (fpos ? 0 : tpf - 1));
      sdin = 1'($urandom % 2);
      pdin = 1'($urandom % 2);
      oe   = !(k >= oe_a && k < oe_b);
      @(negedge clk);
      tdm_ck = ~ckp;
      tdm_fp = fp_hit ? fpp : ~fpp;
      ser_in = sdin; pad_in = pdin; out_en = oe;
      repeat (2) @(negedge clk);
      tdm_ck = ckp;
      // reference model of one tick
      prev_out = exp_out; prev_lock = lock_m;
      deff  = bd ? pdin : sdin;
      align = fpos ? fp_hit : fpl_m;
      idx   = align ? 0 : ((pos_m == tpf - 1) ? 0 : pos_m + 1);
      pos_m = idx; fpl_m = fp_hit;
      if (align) lock_m = 1;
      exp_v = 0; exp_c = 0; exp_b = 0;
      if (lock_m) begin
        if (idx % tpi == tpi - 1) begin
          b = idx / tpi;
          acc = ((acc << 1) | int'(deff)) & 255;
          if (b % 8 == 7) begin exp_v = 1; exp_c = b / 8; exp_b = acc; end
        end
        if (idx % tpo == 0) begin
          b = idx / tpo;
          exp_out = (int'(pat(8'(b / 8))) >> (7 - (b % 8))) & 1;
        end
      end
      @(negedge clk);
      // R12: nothing visible one cycle after the edge
      if (exp_v) chk(rx_valid == 1'b0, "R12", "early rx_valid", int'(rx_valid), 0);
      if (prev_lock) chk(int'(ser_out) == prev_out, "R12", "early ser_out", int'(ser_out), prev_out);
      @(negedge clk);
      chk(ser_oe == (lock_m && oe), oe ? "R11" : "R10", "ser_oe", int'(ser_oe), int'(lock_m && oe));
      chk(rx_valid == exp_v, lbl, "R7 rx_valid", int'(rx_valid), int'(exp_v));
      if (exp_v) begin
        chk(int'(rx_byte) == exp_b, lbl, "R7 rx_byte", int'(rx_byte), exp_b);
        chk(int'(rx_chan) == exp_c, lbl, "R1 rx_chan", int'(rx_chan), exp_c);
      end
      if (lock_m) chk(int'(ser_out) == exp_out, lbl, "R8 ser_out", int'(ser_out), exp_out);
      @(negedge clk);
      chk(rx_valid == 1'b0, lbl, "R7 strobe width", int'(rx_valid), 0);
      gen_t++;
    end
  endtask

  initial begin
    rst_n = 1'b0; tdm_ck = 1'b1; tdm_fp = 1'b1; ser_in = 1'b0; pad_in = 1'b0;
    bidir_en = 1'b0; out_en = 1'b0; in_rate = 2'd0; out_rate = 2'd0;
    ck_pol = 1'b0; fp_pol = 1'b0; fp_pos = 1'b0;
    // defaults: lowest rate, falling edge, active-low pulse ahead of boundary
    run_phase(0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 700, -1, -1, "R1 R2 R4 R5 R6");
    // top rate, one tick per bit, active-high pulse
    run_phase(3, 3, 1'b0, 1'b1, 1'b0, 1'b0, 2300, -1, -1, "R2 R5 R6");
    // output faster than input, rising edge
    run_phase(1, 2, 1'b1, 1'b0, 1'b0, 1'b0, 2300, -1, -1, "R3 R4");
    // input faster than output, pulse inside the first tick
    run_phase(3, 0, 1'b1, 1'b1, 1'b1, 1'b0, 2300, -1, -1, "R3 R4 R5 R6");
    // pad as input, output enable dropped for a while
    run_phase(2, 3, 1'b0, 1'b0, 1'b1, 1'b1, 2300, 500, 900, "R9 R10 R6");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R11 actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule